// File: doc/BRIEF.md
# Seven-Pin GPIO Port with Timer Channel Override

This block is a general-purpose I/O port with seven pins. Software reaches it over a byte-wide register bus. The bus has an address, a write enable, write data and read data that is decoded without a clock. There are two registers. The output latch register holds the value each pin drives when it is a general-purpose output. The direction register enables each pin's output buffer. Inputs from the pads pass through a two-flop synchronizer before they reach the read path.

Six of the pins can be handed to timer channels. Pins 0 to 3 go to channels 2 to 5 of the first timer. Pins 4 and 5 go to channels 0 and 1 of the second timer. When the timer owns a pin, the timer's output value and output enable drive the pad, and the direction bit has no effect on driving. The direction bit still chooses what a read of the latch register returns for that pin.

The direction bits clear on reset. The output latches are not reset and keep their contents through it.

Top module: `tpio_port`

## Requirements
- R1: While reset is asserted and after reset, every direction bit is 0. A read of address 0x0D returns 0x00, and padOe is 0 for every pin the timer does not own.
- R2: A write to byte address 0x0D loads bits 6..0 into the direction register. From the next cycle, padOe[i] of each pin the timer does not own equals direction bit i. A read of 0x0D returns the stored bits.
- R3: A write to byte address 0x09 always loads bits 6..0 into the output latches, whatever the direction and ownership. padOut[i] of each pin the timer does not own equals latch bit i from the next cycle.
- R4: Reset leaves the output latches unchanged.
- R5: A read of 0x09 returns latch bit i where direction bit i is 1. Where direction bit i is 0, it returns pin i sampled through two flops, so a pad change is first visible after the second rising edge.
- R6: Where tmrOwn[k] is 1 (k in 0..5), padOut[k] = tmrOut[k] and padOe[k] = tmrOe[k], whatever direction bit k holds. Pin 6 has no timer and always follows its direction and latch bits.
- R7: The read-source rule of R5 applies unchanged to pins the timer owns.
- R8: Bit 7 of both registers always reads 0, and writing it has no effect. Writes to any address other than 0x09 and 0x0D change nothing. Reads from those addresses return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 8 | Register byte address |
| regWe | input | 1 | Write enable, sampled on the rising edge |
| regWdata | input | 8 | Write data |
| regRdata | output | 8 | Read data for regAddr, combinational |
| padIn | input | 7 | Pad input levels (asynchronous) |
| padOut | output | 7 | Pad output values |
| padOe | output | 7 | Pad output buffer enables |
| tmrOwn | input | 6 | Timer owns pin k when bit k is 1 |
| tmrOut | input | 6 | Timer output value for pin k |
| tmrOe | input | 6 | Timer output enable for pin k |

## Verification
Register writes take effect on the rising edge that samples regWe. padOut and padOe are therefore due one edge after a write. Register reads are combinational and due in the same cycle as the address. Timer inputs reach the pads with no clock edge in between. A pad level reaches read data only after two rising edges. The bench drives and samples at falling edges. For input pins it checks that the old value is still present after one edge and the new one after the second.

// File: rtl/tpio_pkg.sv
package tpio_pkg;
  localparam int unsigned ADDR_W = 8;
  localparam int unsigned DATA_W = 8;
  localparam logic [ADDR_W-1:0] ADDR_LATCH = 8'h09;
  localparam logic [ADDR_W-1:0] ADDR_DIR   = 8'h0D;

  typedef struct packed {
    logic wrLatch;
    logic wrDir;
    logic selLatch;
    logic selDir;
  } tpioStrobe_t;
endpackage

// File: rtl/tpio_ctrl.sv
module tpio_ctrl
  import tpio_pkg::*;
#(
  parameter logic [ADDR_W-1:0] LATCH_ADDR = ADDR_LATCH,
  parameter logic [ADDR_W-1:0] DIR_ADDR   = ADDR_DIR
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  output tpioStrobe_t       strb
);
  logic hitLatch, hitDir;

  always_comb begin
    hitLatch      = (regAddr == LATCH_ADDR);
    hitDir        = (regAddr == DIR_ADDR);
    strb.selLatch = hitLatch;
    strb.selDir   = hitDir;
    strb.wrLatch  = regWe && hitLatch;
    strb.wrDir    = regWe && hitDir;
  end
endmodule

// File: rtl/tpio_dpath.sv
module tpio_dpath
  import tpio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 7,
  parameter int unsigned NUM_TMR     = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  tpioStrobe_t         strb,
  input  logic [DATA_W-1:0]   wdata,
  output logic [DATA_W-1:0]   rdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  input  logic [NUM_TMR-1:0]  tmrOwn,
  input  logic [NUM_TMR-1:0]  tmrOut,
  input  logic [NUM_TMR-1:0]  tmrOe
);
  localparam int unsigned FREE_W = NUM_PINS - NUM_TMR;

  logic [NUM_PINS-1:0] outLatch;
  logic [NUM_PINS-1:0] dirReg;
  logic [NUM_PINS-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncIn;
  logic [NUM_PINS-1:0] readBits;
  logic [NUM_PINS-1:0] freeMask;

  // Output latches: no reset, so contents survive reset.
  always_ff @(posedge clk) begin
    if (strb.wrLatch) outLatch <= wdata[NUM_PINS-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          dirReg <= '0;
    else if (strb.wrDir) dirReg <= wdata[NUM_PINS-1:0];
  end

  // Input synchronizer chain.
  genvar s;
  generate
    for (s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncPipe[s] <= '0;
        else if (s == 0) syncPipe[s] <= padIn;
        else syncPipe[s] <= syncPipe[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate
  assign syncIn = syncPipe[SYNC_STAGES-1];

  // Pad drive per pin; timer-capable pins get an override mux.
  genvar i;
  generate
    for (i = 0; i < NUM_PINS; i++) begin : g_pin
      if (i < NUM_TMR) begin : g_tmr
        assign padOut[i] = tmrOwn[i] ? tmrOut[i] : outLatch[i];
        assign padOe[i]  = tmrOwn[i] ? tmrOe[i]  : dirReg[i];
      end else begin : g_plain
        assign padOut[i] = outLatch[i];
        assign padOe[i]  = dirReg[i];
      end
    end
  endgenerate

  assign freeMask = ~{{FREE_W{1'b0}}, tmrOwn};
  assign readBits = (dirReg & outLatch) | (~dirReg & syncIn);

  always_comb begin
    if (strb.selLatch)    rdata = DATA_W'(readBits);
    else if (strb.selDir) rdata = DATA_W'(dirReg);
    else                  rdata = '0;
  end

  // R1: no pin the timer does not own drives while in reset
  always_comb begin
    if (!rstN) p_dir_reset_r1: assert ((padOe & freeMask) == '0);
  end

  // R2: a direction write reaches the output enables one cycle later
  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDir |=> ((padOe & freeMask) == ($past(wdata[NUM_PINS-1:0]) & freeMask)));

  // R3: a latch write reaches padOut of pins the timer does not own one cycle later
  p_latch_drive_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrLatch |=> ((padOut & freeMask) == ($past(wdata[NUM_PINS-1:0]) & freeMask)));

  // R8: the reserved top bit never reads as 1
  always_comb begin
    p_bit7_zero_r8: assert (rdata[DATA_W-1:NUM_PINS] == '0);
  end

  // R2: the direction register holds its value when no direction write occurs
  p_dir_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrDir |=> $stable(dirReg));
endmodule

// File: rtl/tpio_port.sv
module tpio_port
  import tpio_pkg::*;
#(
  parameter int unsigned NUM_PINS = 7,
  parameter int unsigned NUM_TMR  = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [7:0]          regAddr,
  input  logic                regWe,
  input  logic [7:0]          regWdata,
  output logic [7:0]          regRdata,
  input  logic [NUM_PINS-1:0] padIn,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  input  logic [NUM_TMR-1:0]  tmrOwn,
  input  logic [NUM_TMR-1:0]  tmrOut,
  input  logic [NUM_TMR-1:0]  tmrOe
);
  tpioStrobe_t strb;

  tpio_ctrl u_ctrl (
    .regAddr (regAddr),
    .regWe   (regWe),
    .strb    (strb)
  );

  tpio_dpath #(.NUM_PINS(NUM_PINS), .NUM_TMR(NUM_TMR)) u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .wdata  (regWdata),
    .rdata  (regRdata),
    .padIn  (padIn),
    .padOut (padOut),
    .padOe  (padOe),
    .tmrOwn (tmrOwn),
    .tmrOut (tmrOut),
    .tmrOe  (tmrOe)
  );
endmodule

// File: tb/sim_tpio_port.sv
module sim_tpio_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_LAT = 8'h09;
  localparam logic [7:0] A_DIR = 8'h0D;

  logic clk = 0;
  logic rstN = 0;
  logic [7:0] regAddr = 8'h00;
  logic regWe = 0;
  logic [7:0] regWdata = 8'h00;
  logic [7:0] regRdata;
  logic [6:0] padIn = 7'h00;
  logic [6:0] padOut, padOe;
  logic [5:0] tmrOwn = 6'h00, tmrOut = 6'h00, tmrOe = 6'h00;

  int nChecks = 0;
  int nFails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tpio_port u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .regRdata(regRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .tmrOwn(tmrOwn), .tmrOut(tmrOut),
    .tmrOe(tmrOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; regWdata = d; regWe = 1;
    @(negedge clk);
    regWe = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = regRdata;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    #1;
    check("R1 oe in reset", {1'b0, padOe}, 8'h00);
    rd(A_DIR, v); check("R1 dir in reset", v, 8'h00);
    @(negedge clk); @(negedge clk);
    rstN = 1;
    @(negedge clk);
    check("R1 oe after reset", {1'b0, padOe}, 8'h00);
  endtask

  task automatic t_dir_write();
    logic [7:0] v;
    wr(A_DIR, 8'hFF);
    check("R2 oe all", {1'b0, padOe}, 8'h7F);
    rd(A_DIR, v); check("R8 dir bit7 reads 0", v, 8'h7F);
    wr(A_DIR, 8'h2A);
    check("R2 oe pattern", {1'b0, padOe}, 8'h2A);
    rd(A_DIR, v); check("R2 dir readback", v, 8'h2A);
  endtask

  task automatic t_latch_mixed();
    logic [7:0] v;
    wr(A_LAT, 8'h35);
    check("R3 padOut", {1'b0, padOut}, 8'h35);
    rd(A_LAT, v); check("R5 mixed read", v, 8'h20);
  endtask

  task automatic t_input_sync();
    logic [7:0] v;
    wr(A_DIR, 8'h00);
    padIn = 7'h5A;
    @(negedge clk);
    rd(A_LAT, v); check("R5 one edge old value", v, 8'h00);
    @(negedge clk);
    rd(A_LAT, v); check("R5 two edges new value", v, 8'h5A);
    wr(A_LAT, 8'h0F);
    check("R3 write while input", {1'b0, padOut}, 8'h0F);
  endtask

  task automatic t_retention();
    logic [7:0] v;
    wr(A_LAT, 8'h63);
    @(negedge clk); rstN = 0;
    @(negedge clk); rstN = 1;
    @(negedge clk);
    rd(A_DIR, v); check("R1 dir cleared by reset", v, 8'h00);
    check("R4 padOut kept", {1'b0, padOut}, 8'h63);
    wr(A_DIR, 8'h7F);
    rd(A_LAT, v); check("R4 latch read after reset", v, 8'h63);
  endtask

  task automatic t_timer();
    wr(A_DIR, 8'h00);
    tmrOwn = 6'h3F; tmrOe = 6'h15; tmrOut = 6'h0C;
    #1;
    check("R6 oe owned dir0", {1'b0, padOe}, 8'h15);
    check("R6 out owned", {1'b0, padOut}, 8'h4C);
    wr(A_DIR, 8'h7F);
    check("R6 oe owned dir1", {1'b0, padOe}, 8'h55);
    wr(A_LAT, 8'h2A);
    check("R3 write while owned", {1'b0, padOut}, 8'h0C);
    tmrOwn = 6'h00;
    #1;
    check("R3 released pins drive latch", {1'b0, padOut}, 8'h2A);
    wr(A_LAT, 8'h63);
    tmrOwn = 6'h3F;
  endtask

  task automatic t_read_owned();
    logic [7:0] v;
    padIn = 7'h1C;
    @(negedge clk); @(negedge clk);
    rd(A_LAT, v); check("R7 owned dir1 reads latch", v, 8'h63);
    wr(A_DIR, 8'h0F);
    rd(A_LAT, v); check("R7 owned mixed read", v, 8'h13);
    wr(A_DIR, 8'h00);
    rd(A_LAT, v); check("R7 owned dir0 reads pins", v, 8'h1C);
    tmrOwn = 6'h00;
  endtask

  task automatic t_reserved();
    logic [7:0] v;
    wr(A_DIR, 8'h7F);
    wr(A_LAT, 8'h91);
    rd(A_LAT, v); check("R8 latch bit7 ignored", v, 8'h11);
    wr(8'h0A, 8'hFF);
    wr(8'h00, 8'h00);
    check("R8 unmapped write padOut", {1'b0, padOut}, 8'h11);
    check("R8 unmapped write padOe", {1'b0, padOe}, 8'h7F);
    rd(8'h0A, v); check("R8 unmapped read", v, 8'h00);
    rd(8'hFF, v); check("R8 unmapped read high", v, 8'h00);
  endtask

  initial begin
    t_reset();
    t_dir_write();
    t_latch_mixed();
    t_input_sync();
    t_retention();
    t_timer();
    t_read_owned();
    t_reserved();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      nChecks++; nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule